// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block keeps several private caches coherent over one shared broadcast bus. Each cache is direct-mapped. Every line holds a sharing status, a tag and one data word, and in this model a word is the whole block. A local write may only complete once the cache owns the line exclusively, so any write that does not already own the line wins the bus and broadcasts an invalidate. Every other cache watches the bus. A cache drops its copy when it sees an invalidate for an address it holds. When it sees a read miss for a line it holds dirty, it supplies that data, which also writes it back to memory.

A round-robin arbiter admits one bus transaction per cycle, so all writes are serialized. Each processor port holds its request until a one-cycle done pulse. A small word memory behind the bus serves fills, dirty-data flushes and victim write-backs. A peek port reports every cache's status for any address, so that the single-owner rule can be observed from outside.

Top module: `snoop_coh_top`

## Requirements
- R1: After reset every line of every cache is Invalid, the bus command is idle (0), no done pulse is raised and every memory word reads as 0.
- R2: A read that hits a Shared or Modified line completes with a done pulse one cycle after the request is seen, and issues no bus transaction.
- R3: A read miss broadcasts command code 1 and installs the line Shared. If another cache holds the line Modified, that cache supplies the word, moves to Shared and the word is written to memory.
- R4: A write miss broadcasts command code 2 and installs the line Modified with the written word. Every other copy of that address becomes Invalid.
- R5: A write hit on a Shared line broadcasts command code 3 (invalidate) and then moves to Modified. A write hit on a Modified line completes locally in one cycle with no bus transaction.
- R6: The arbiter grants at most one cache per cycle, and only a cache that is requesting. Priority rotates to start at the cache after the last one granted, and cache 0 comes first after reset.
- R7: No address is ever Modified in more than one cache, nor Modified in one cache while Shared in another. The peek field for cache i sits at bits [2i+1:2i], with 0 = Invalid, 1 = Shared and 2 = Modified.
- R8: Every read returns the value of the last completed write to that address, or 0 if the address was never written.
- R9: A miss that replaces a Modified line with a different tag writes the old word to memory in the same bus transaction.
- R10: When a snooped transaction hits the index that a local request needs in the same cycle, the snoop takes effect first and the local request is re-evaluated on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORE | Per-cache request, held until done |
| req_write | input | NCORE | Per-cache write (1) or read (0) |
| req_addr | input | NCORE*AW | Per-cache word address, cache i at [AW*i +: AW] |
| req_wdata | input | NCORE*DW | Per-cache write data |
| req_done | output | NCORE | One-cycle completion pulse per cache |
| req_rdata | output | NCORE*DW | Read data, valid with done |
| bus_grant | output | NCORE | One-hot grant of the current bus transaction |
| bus_cmd | output | 2 | Broadcast command: 0 idle, 1 read miss, 2 write miss, 3 invalidate |
| bus_addr | output | AW | Broadcast address |
| peek_addr | input | AW | Address whose status is reported |
| peek_state | output | 2*NCORE | Status of peek_addr in each cache |

## Verification
Two functions can fall in one cycle. The first is a snooped transaction from another cache. The second is a local write hit on the same line, which could otherwise be applied to a line that the snoop is demoting at that edge. The bench provokes this by starting a read miss in one cache and, one cycle later, a write to the same address in the cache that holds it Modified. The two then meet exactly at the grant edge. The judgement is deterministic: the reader gets the old word, the writer follows with an invalidate, and afterwards the writer holds the line Modified and the reader holds it Invalid.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_M = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_RD   = 2'd1,
        BC_RDX  = 2'd2,
        BC_UPG  = 2'd3
    } bus_cmd_t;

endpackage

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IXW = (N > 1) ? $clog2(N) : 1;

    logic [IXW-1:0] last_q, last_d;

    always_comb begin
        logic found;
        found  = 1'b0;
        gnt    = '0;
        last_d = last_q;
        for (int k = 1; k <= N; k++) begin
            int j;
            j = (int'(last_q) + k) % N;
            if (!found && req[j]) begin
                found  = 1'b1;
                gnt[j] = 1'b1;
                last_d = IXW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= IXW'(N - 1);
        else        last_q <= last_d;
    end

    // R6: one grant at a time, never to an idle requester
    a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    a_r6_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int AW = 4,
    parameter int IW = 2,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_done,
    output logic [DW-1:0] req_rdata,
    output logic          bus_req,
    input  logic          bus_gnt,
    output bus_cmd_t      cmd_o,
    output logic [AW-1:0] addr_o,
    output logic          wb_en,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data,
    input  bus_cmd_t      snp_cmd,
    input  logic [AW-1:0] snp_addr,
    output logic          snp_flush,
    output logic [DW-1:0] snp_data,
    input  logic [DW-1:0] fill_data,
    input  logic [AW-1:0] peek_addr,
    output line_st_t      peek_state
);
    localparam int TW    = AW - IW;
    localparam int LINES = 1 << IW;

    typedef struct packed {
        line_st_t      st;
        logic [TW-1:0] tag;
        logic [DW-1:0] data;
    } line_t;

    typedef enum logic [1:0] {FS_IDLE, FS_BUS, FS_RESP} fsm_t;

    typedef struct packed {
        line_t [LINES-1:0] lines;
        fsm_t              fsm;
        logic              done;
        logic [DW-1:0]     rdata;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic [IW-1:0] req_idx, snp_idx, pk_idx;
    logic [TW-1:0] req_tag, snp_tag, pk_tag;
    line_t         rl, sl, pl;
    logic          req_hit, snp_match, snp_kill, snp_same_idx;
    bus_cmd_t      want_cmd;

    always_comb begin
        req_idx = req_addr[IW-1:0];
        req_tag = req_addr[AW-1:IW];
        snp_idx = snp_addr[IW-1:0];
        snp_tag = snp_addr[AW-1:IW];
        pk_idx  = peek_addr[IW-1:0];
        pk_tag  = peek_addr[AW-1:IW];
        rl      = cur_q.lines[req_idx];
        sl      = cur_q.lines[snp_idx];
        pl      = cur_q.lines[pk_idx];

        req_hit      = (rl.st != LN_I) && (rl.tag == req_tag);
        // snoops from other caches only; the granted cache sees its own cmd
        snp_match    = (snp_cmd != BC_NONE) && !bus_gnt &&
                       (sl.st != LN_I) && (sl.tag == snp_tag);
        snp_kill     = snp_match && (snp_cmd == BC_RDX || snp_cmd == BC_UPG);
        snp_flush    = snp_match && (sl.st == LN_M);
        snp_data     = sl.data;
        snp_same_idx = (snp_cmd != BC_NONE) && !bus_gnt && (snp_idx == req_idx);

        if (!req_write)                     want_cmd = BC_RD;
        else if (req_hit && rl.st == LN_S)  want_cmd = BC_UPG;
        else                                want_cmd = BC_RDX;

        bus_req = (cur_q.fsm == FS_BUS);
        cmd_o   = bus_gnt ? want_cmd : BC_NONE;
        addr_o  = bus_gnt ? req_addr : '0;
        wb_en   = bus_gnt && (rl.st == LN_M) && (rl.tag != req_tag);
        wb_addr = {rl.tag, req_idx};
        wb_data = rl.data;

        peek_state = ((pl.st != LN_I) && (pl.tag == pk_tag)) ? pl.st : LN_I;
        req_done   = cur_q.done;
        req_rdata  = cur_q.rdata;
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;

        // snoop side
        if (snp_kill)
            nxt_d.lines[snp_idx].st = LN_I;
        else if (snp_match && snp_cmd == BC_RD && sl.st == LN_M)
            nxt_d.lines[snp_idx].st = LN_S;

        // processor side
        unique case (cur_q.fsm)
            FS_IDLE: begin
                if (req_valid && !snp_same_idx) begin
                    if (!req_write && req_hit) begin
                        nxt_d.rdata = rl.data;
                        nxt_d.done  = 1'b1;
                        nxt_d.fsm   = FS_RESP;
                    end else if (req_write && req_hit && rl.st == LN_M) begin
                        nxt_d.lines[req_idx].data = req_wdata;
                        nxt_d.done = 1'b1;
                        nxt_d.fsm  = FS_RESP;
                    end else begin
                        nxt_d.fsm = FS_BUS;
                    end
                end
            end
            FS_BUS: begin
                if (bus_gnt) begin
                    nxt_d.lines[req_idx].tag = req_tag;
                    if (req_write) begin
                        nxt_d.lines[req_idx].st   = LN_M;
                        nxt_d.lines[req_idx].data = req_wdata;
                    end else begin
                        nxt_d.lines[req_idx].st   = LN_S;
                        nxt_d.lines[req_idx].data = fill_data;
                        nxt_d.rdata = fill_data;
                    end
                    nxt_d.done = 1'b1;
                    nxt_d.fsm  = FS_RESP;
                end
            end
            default: nxt_d.fsm = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                cur_q.lines[i].st   <= LN_I;
                cur_q.lines[i].tag  <= '0;
                cur_q.lines[i].data <= '0;
            end
            cur_q.fsm   <= FS_IDLE;
            cur_q.done  <= 1'b0;
            cur_q.rdata <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    // R2: a granted transaction always completes on the next cycle
    a_r2_grant_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |=> req_done);
    // R4: a snooped write miss or invalidate leaves the copy Invalid
    a_r4_snoop_kills_copy: assert property (@(posedge clk) disable iff (!rst_n)
        snp_kill |=> cur_q.lines[$past(snp_idx)].st == LN_I);
    // R3: a dirty holder that snoops a read miss is left Shared
    a_r3_flush_to_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_flush && snp_cmd == BC_RD) |=> cur_q.lines[$past(snp_idx)].st == LN_S);
    // R5: an invalidate is only issued while the line is still held Shared
    a_r5_upgrade_from_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == BC_UPG) |-> (peek_addr != req_addr || peek_state == LN_S));

endmodule

// File: rtl/snoop_coh_top.sv
module snoop_coh_top
    import coh_pkg::*;
#(
    parameter int NCORE = 3,
    parameter int AW    = 4,
    parameter int IW    = 2,
    parameter int DW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCORE-1:0]    req_valid,
    input  logic [NCORE-1:0]    req_write,
    input  logic [NCORE*AW-1:0] req_addr,
    input  logic [NCORE*DW-1:0] req_wdata,
    output logic [NCORE-1:0]    req_done,
    output logic [NCORE*DW-1:0] req_rdata,
    output logic [NCORE-1:0]    bus_grant,
    output logic [1:0]          bus_cmd,
    output logic [AW-1:0]       bus_addr,
    input  logic [AW-1:0]       peek_addr,
    output logic [2*NCORE-1:0]  peek_state
);
    localparam int MEMD = 1 << AW;

    logic [NCORE-1:0] bus_req_w, flush_w, wb_en_w;
    bus_cmd_t         cmd_w    [NCORE];
    logic [AW-1:0]    addr_w   [NCORE];
    logic [AW-1:0]    wba_w    [NCORE];
    logic [DW-1:0]    wbd_w    [NCORE];
    logic [DW-1:0]    snpd_w   [NCORE];
    line_st_t         pk_w     [NCORE];

    bus_cmd_t      bcmd;
    logic [AW-1:0] baddr;
    logic          any_flush, any_wb;
    logic [DW-1:0] flush_data, fill_data, wb_data;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] mem_q [MEMD];
    logic [DW-1:0] mem_d [MEMD];

    rr_bus_arbiter #(.N(NCORE)) u_arb (
        .clk(clk), .rst_n(rst_n), .req(bus_req_w), .gnt(bus_grant)
    );

    for (genvar i = 0; i < NCORE; i++) begin : g_cache
        coh_line_ctrl #(.AW(AW), .IW(IW), .DW(DW)) u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_valid  (req_valid[i]),
            .req_write  (req_write[i]),
            .req_addr   (req_addr[AW*i +: AW]),
            .req_wdata  (req_wdata[DW*i +: DW]),
            .req_done   (req_done[i]),
            .req_rdata  (req_rdata[DW*i +: DW]),
            .bus_req    (bus_req_w[i]),
            .bus_gnt    (bus_grant[i]),
            .cmd_o      (cmd_w[i]),
            .addr_o     (addr_w[i]),
            .wb_en      (wb_en_w[i]),
            .wb_addr    (wba_w[i]),
            .wb_data    (wbd_w[i]),
            .snp_cmd    (bcmd),
            .snp_addr   (baddr),
            .snp_flush  (flush_w[i]),
            .snp_data   (snpd_w[i]),
            .fill_data  (fill_data),
            .peek_addr  (peek_addr),
            .peek_state (pk_w[i])
        );
        assign peek_state[2*i +: 2] = pk_w[i];
    end

    always_comb begin
        logic [1:0] c;
        c          = '0;
        baddr      = '0;
        flush_data = '0;
        wb_addr    = '0;
        wb_data    = '0;
        for (int i = 0; i < NCORE; i++) begin
            c     = c | cmd_w[i];
            baddr = baddr | addr_w[i];
            if (flush_w[i]) flush_data = flush_data | snpd_w[i];
            if (wb_en_w[i]) begin
                wb_addr = wb_addr | wba_w[i];
                wb_data = wb_data | wbd_w[i];
            end
        end
        bcmd      = bus_cmd_t'(c);
        any_flush = |flush_w;
        any_wb    = |wb_en_w;
        fill_data = any_flush ? flush_data : mem_q[baddr];
        bus_cmd   = c;
        bus_addr  = baddr;
    end

    always_comb begin
        for (int a = 0; a < MEMD; a++) mem_d[a] = mem_q[a];
        if (any_flush) mem_d[baddr]   = flush_data;
        if (any_wb)    mem_d[wb_addr] = wb_data;
    end

    always_ff @(posedge clk) begin
        for (int a = 0; a < MEMD; a++) begin
            if (!rst_n) mem_q[a] <= '0;
            else        mem_q[a] <= mem_d[a];
        end
    end

    // R7: single writer, and no reader alongside a writer, for the peeked address
    logic [$clog2(NCORE+1)-1:0] m_cnt;
    logic                       s_any;
    always_comb begin
        m_cnt = '0;
        s_any = 1'b0;
        for (int i = 0; i < NCORE; i++) begin
            if (pk_w[i] == LN_M) m_cnt = m_cnt + 1'b1;
            if (pk_w[i] == LN_S) s_any = 1'b1;
        end
    end

    a_r7_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cnt <= 1) && !(m_cnt != 0 && s_any));
    // R6: a broadcast only appears while a grant is held
    a_r6_cmd_with_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'd0) |-> $onehot(bus_grant));
    // R3: dirty data is supplied only against a read or write miss
    a_r3_flush_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        any_flush |-> (bcmd == BC_RD || bcmd == BC_RDX));

endmodule

// File: tb/snoop_coh_top_test.sv
module snoop_coh_top_test;
    localparam int NC = 3;
    localparam int AW = 4;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            rv  [NC];
    logic            rw  [NC];
    logic [AW-1:0]   ra  [NC];
    logic [DW-1:0]   rwd [NC];
    logic [NC-1:0]    req_valid, req_write, req_done, bus_grant;
    logic [NC*AW-1:0] req_addr;
    logic [NC*DW-1:0] req_wdata, req_rdata;
    logic [1:0]       bus_cmd;
    logic [AW-1:0]    bus_addr, peek_addr;
    logic [2*NC-1:0]  peek_state;

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            req_valid[i]          = rv[i];
            req_write[i]          = rw[i];
            req_addr[AW*i +: AW]  = ra[i];
            req_wdata[DW*i +: DW] = rwd[i];
        end
    end

    snoop_coh_top #(.NCORE(NC), .AW(AW), .IW(2), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata),
        .bus_grant(bus_grant), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .peek_addr(peek_addr), .peek_state(peek_state)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [DW-1:0] gold [16];

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int st_of(input int c);
        return int'(peek_state[2*c +: 2]);
    endfunction

    task automatic access(input int c, input bit w, input int a, input int d,
                          output int rd, output int lat, output int cmd);
        @(negedge clk);
        rv[c] = 1'b1; rw[c] = w; ra[c] = AW'(a); rwd[c] = DW'(d);
        lat = 0; cmd = 0;
        do begin
            @(negedge clk);
            lat++;
            if (bus_grant[c]) cmd = int'(bus_cmd);
        end while (!req_done[c] && lat < 100);
        rd = int'(req_rdata[DW*c +: DW]);
        rv[c] = 1'b0;
        if (lat >= 100) chk(0, "R2 request timeout", lat, 2);
    endtask

    // returns per-core state of one address, sampled mid-cycle
    task automatic peek(input int a, output int s0, output int s1, output int s2);
        @(negedge clk);
        peek_addr = AW'(a);
        #1;
        s0 = st_of(0); s1 = st_of(1); s2 = st_of(2);
    endtask

    task automatic check_inv();
        bit ok = 1;
        for (int a = 0; a < 16; a++) begin
            int s0, s1, s2, m, s;
            peek(a, s0, s1, s2);
            m = (s0 == 2) + (s1 == 2) + (s2 == 2);
            s = (s0 == 1) + (s1 == 1) + (s2 == 1);
            if (m > 1 || (m == 1 && s > 0)) ok = 0;
        end
        chk(ok, "R7 single owner invariant", ok, 1);
    endtask

    task automatic op(input int c, input bit w, input int a, input int d);
        int rd, lat, cmd;
        access(c, w, a, d, rd, lat, cmd);
        if (w) gold[a] = DW'(d);
        else chk(rd == int'(gold[a]), "R8 read returns last write", rd, int'(gold[a]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int rd, lat, cmd, s0, s1, s2, rd_a, lat_a, cmd_a, lat_b, cmd_b, rd_b;
        logic [15:0] lf;
        for (int i = 0; i < NC; i++) begin rv[i] = 0; rw[i] = 0; ra[i] = '0; rwd[i] = '0; end
        for (int a = 0; a < 16; a++) gold[a] = '0;
        peek_addr = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(bus_cmd == 2'd0, "R1 bus idle", int'(bus_cmd), 0);
        chk(req_done == '0, "R1 no done", int'(req_done), 0);
        begin
            bit ok = 1;
            for (int a = 0; a < 16; a++) begin
                peek(a, s0, s1, s2);
                if (s0 != 0 || s1 != 0 || s2 != 0) ok = 0;
            end
            chk(ok, "R1 all lines Invalid", ok, 1);
        end

        // R3/R8: A reads X, B reads X, A writes 1, B reads X
        access(0, 0, 5, 0, rd, lat, cmd);
        chk(cmd == 1, "R3 read miss command", cmd, 1);
        chk(rd == 0, "R1 memory reads zero", rd, 0);
        access(1, 0, 5, 0, rd, lat, cmd);
        peek(5, s0, s1, s2);
        chk(s0 == 1 && s1 == 1, "R3 both Shared", s0 * 10 + s1, 11);
        access(0, 1, 5, 1, rd, lat, cmd);
        chk(cmd == 3, "R5 shared write hit invalidates", cmd, 3);
        peek(5, s0, s1, s2);
        chk(s0 == 2 && s1 == 0, "R5 writer Modified other Invalid", s0 * 10 + s1, 20);
        access(1, 0, 5, 0, rd, lat, cmd);
        chk(rd == 1, "R3 dirty holder supplies word", rd, 1);
        chk(cmd == 1, "R3 reread is miss", cmd, 1);
        peek(5, s0, s1, s2);
        chk(s0 == 1 && s1 == 1, "R3 holder demoted to Shared", s0 * 10 + s1, 11);
        gold[5] = 8'd1;
        op(0, 0, 13, 0); op(1, 0, 13, 0);
        access(2, 0, 5, 0, rd, lat, cmd);
        chk(rd == 1, "R3 memory updated by flush", rd, 1);
        check_inv();

        // R5 local write on Modified
        access(2, 1, 5, 8'h22, rd, lat, cmd);
        chk(cmd == 3, "R5 upgrade from Shared", cmd, 3);
        access(2, 1, 5, 8'h33, rd, lat, cmd);
        chk(cmd == 0 && lat == 1, "R5 Modified write is local", cmd * 10 + lat, 1);
        gold[5] = 8'h33;
        op(0, 0, 5, 0);

        // R4 write miss
        access(0, 1, 6, 8'h44, rd, lat, cmd);
        chk(cmd == 2, "R4 write miss command", cmd, 2);
        access(1, 1, 6, 8'h55, rd, lat, cmd);
        peek(6, s0, s1, s2);
        chk(s0 == 0 && s1 == 2, "R4 other copy Invalid", s0 * 10 + s1, 2);
        gold[6] = 8'h55;
        check_inv();

        // R9 victim write-back
        access(1, 1, 14, 8'h66, rd, lat, cmd);
        gold[14] = 8'h66;
        access(2, 0, 6, 0, rd, lat, cmd);
        chk(rd == 8'h55, "R9 evicted dirty word in memory", rd, 8'h55);

        // R2 read hit latency
        access(1, 0, 14, 0, rd, lat, cmd);
        chk(lat == 1 && cmd == 0 && rd == 8'h66, "R2 read hit local", lat * 1000 + rd, 1000 + 8'h66);
        access(0, 0, 10, 0, rd, lat, cmd);
        chk(lat == 2, "R3 uncontended miss latency", lat, 2);

        // R10 snoop and local write hit on the same line in one cycle
        op(0, 1, 9, 8'hA1);
        fork
            access(1, 0, 9, 0, rd_a, lat_a, cmd_a);
            begin @(negedge clk); access(0, 1, 9, 8'hB2, rd_b, lat_b, cmd_b); end
        join
        chk(rd_a == 8'hA1, "R10 snoop served before local write", rd_a, 8'hA1);
        chk(cmd_b == 3, "R10 deferred write upgrades", cmd_b, 3);
        peek(9, s0, s1, s2);
        chk(s0 == 2 && s1 == 0, "R10 final states", s0 * 10 + s1, 20);
        gold[9] = 8'hB2;
        op(1, 0, 9, 0);

        // R6 rotation: last grant to core 0, then cores 0 and 1 together
        op(0, 0, 3, 0);
        fork
            access(0, 0, 7, 0, rd_a, lat_a, cmd_a);
            access(1, 0, 11, 0, rd_b, lat_b, cmd_b);
        join
        chk(lat_b == 2 && lat_a == 3, "R6 core after last grant wins", lat_a * 10 + lat_b, 32);
        fork
            access(0, 0, 3, 0, rd_a, lat_a, cmd_a);
            access(2, 0, 3, 0, rd_b, lat_b, cmd_b);
        join
        chk(lat_b == 2 && lat_a == 3, "R6 priority rotates to core 2", lat_a * 10 + lat_b, 32);
        check_inv();

        // sweep of mixed traffic over all addresses and caches
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op(int'(lf[1:0]) % 3, lf[2], int'(lf[6:3]), int'(lf[15:8]));
            if (n % 40 == 0) check_inv();
        end
        check_inv();

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule